// File: doc/BRIEF.md
# UART Interrupt Pin Generator

This block drives the single interrupt pin of one UART channel. It looks at the state of the transmitter and the receiver and raises an interrupt request when one of them needs service. How each side is judged depends on the FIFO-enable control bit.

With the FIFOs disabled, each side is judged by the occupancy flag of its one-byte holding register. The transmitter wants service when its register is empty. The receiver wants service when its register holds a byte. With the FIFOs enabled, each side compares its fill count against its own programmable trigger level.

The transmit and receive requests each pass through their own enable. The enabled requests are ORed together and registered. The registered level then goes out on the pin in the polarity chosen by the bus-mode select: active high when the select is 1, active low when it is 0. The legacy DMA-mode control bit is accepted on a port but has no influence on the pin.

Top module: `uart_irq_gen`

## Requirements
- R1: With `fifo_en`=0, the transmit request is active exactly when `thr_full`=0 (holding register empty).
- R2: With `fifo_en`=1, the transmit request is active when `tx_count` < `tx_trig` or `tx_count`=0. It is inactive when `tx_count` is nonzero and at or above `tx_trig`.
- R3: With `fifo_en`=0, the receive request is active exactly when `rhr_full`=1 (one byte held).
- R4: With `fifo_en`=1, the receive request is active when `rx_count` is nonzero and `rx_count` >= `rx_trig`. It is inactive when the FIFO is empty or the count is below `rx_trig`.
- R5: With `intel_mode`=1, `irq_pin` is 1 when a request is active and 0 otherwise. With `intel_mode`=0, `irq_pin` is 0 when a request is active and 1 otherwise.
- R6: `dma_mode` has no effect: either value gives the same `irq_pin` sequence.
- R7: A fill count equal to its trigger level counts as reaching it. At that count the receive request is active and the transmit request is inactive.
- R8: The transmit request counts only when `tx_ien`=1, and the receive request only when `rx_ien`=1. The pin reflects the OR of the enabled requests.
- R9: `irq_pin` is registered. It changes on the first rising clock edge after its inputs change, and not before.
- R10: While `rst_n`=0 at a rising edge, `irq_pin` takes the inactive level for the present `intel_mode`: 0 when `intel_mode`=1, 1 when `intel_mode`=0.
- R11: Toggling `intel_mode` while a request is active inverts `irq_pin` on the next edge, with no intermediate value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fifo_en | input | 1 | 1 selects trigger-level comparison, 0 selects holding-register flags |
| dma_mode | input | 1 | Legacy DMA-mode bit, ignored |
| intel_mode | input | 1 | Pin polarity: 1 active high, 0 active low |
| tx_ien | input | 1 | Transmit request enable |
| rx_ien | input | 1 | Receive request enable |
| thr_full | input | 1 | Transmit holding register holds a byte |
| rhr_full | input | 1 | Receive holding register holds a byte |
| tx_count | input | CNT_W | Transmit FIFO fill count |
| tx_trig | input | CNT_W | Transmit trigger level |
| rx_count | input | CNT_W | Receive FIFO fill count |
| rx_trig | input | CNT_W | Receive trigger level |
| irq_pin | output | 1 | Interrupt pin |

## Verification
The bench drives counts at, one below and one above each trigger level. A comparator with the wrong strictness would flip the pin exactly at equality. It also covers a trigger level of zero with an empty FIFO. There, a design that ignored the empty term would raise a receive request with nothing stored, or drop the transmit request on an empty FIFO.

The bench toggles the mode select while a request is held, and samples the pin immediately after each input change. A missing register, an inverted polarity or a stale mode would show up there. The reset value is checked under both modes, and DMA-mode toggles are interleaved with ordinary traffic to expose any hidden dependence on that bit.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef struct packed {
        logic pin;
        logic act;
    } irq_state_t;

    function automatic logic drive_level(input logic act, input logic active_high);
        return active_high ? act : ~act;
    endfunction

endpackage

// File: rtl/uart_irq_tx_eval.sv
module uart_irq_tx_eval #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             thr_full,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] trig,
    output logic             hit
);
    localparam logic [CNT_W-1:0] ZERO = '0;

    logic below_trig;
    logic fifo_empty;
    logic fifo_hit;

    always_comb begin
        below_trig = (count < trig);
        fifo_empty = (count == ZERO);
        fifo_hit   = below_trig | fifo_empty;
        hit        = fifo_en ? fifo_hit : ~thr_full;
    end

    AST_TX_AT_TRIG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && count != ZERO && count >= trig) |-> !hit); // R7
    AST_TX_EMPTY_WANTS: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && count == ZERO) |-> hit); // R2
    AST_TX_REG_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && !thr_full) |-> hit); // R1

endmodule

// File: rtl/uart_irq_rx_eval.sv
module uart_irq_rx_eval #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             rhr_full,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] trig,
    output logic             hit
);
    localparam logic [CNT_W-1:0] ZERO = '0;

    logic at_trig;
    logic has_data;

    always_comb begin
        at_trig  = (count >= trig);
        has_data = (count != ZERO);
        hit      = fifo_en ? (at_trig & has_data) : rhr_full;
    end

    AST_RX_AT_TRIG_WANTS: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && count != ZERO && count >= trig) |-> hit); // R7
    AST_RX_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && count == ZERO) |-> !hit); // R4
    AST_RX_REG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && rhr_full) |-> hit); // R3

endmodule

// File: rtl/uart_irq_pin_reg.sv
module uart_irq_pin_reg
    import uart_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic intel_mode,
    input  logic tx_ien,
    input  logic rx_ien,
    input  logic tx_hit,
    input  logic rx_hit,
    output logic pin
);
    irq_state_t st_d;
    irq_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.act = 1'b0;
        end else begin
            st_d.act = (tx_ien & tx_hit) | (rx_ien & rx_hit);
        end
        st_d.pin = drive_level(st_d.act, intel_mode);
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pin = st_q.pin;

    AST_PIN_FOLLOWS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pin == ($past(intel_mode) ? st_q.act : !st_q.act))); // R5
    AST_NO_ENABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_ien && !rx_ien) |=> (pin == !$past(intel_mode))); // R8

endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen #(
    parameter int FIFO_DEPTH = 16,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             dma_mode,
    input  logic             intel_mode,
    input  logic             tx_ien,
    input  logic             rx_ien,
    input  logic             thr_full,
    input  logic             rhr_full,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] tx_trig,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_trig,
    output logic             irq_pin
);
    logic tx_hit;
    logic rx_hit;
    logic unused_dma;

    assign unused_dma = dma_mode;

    uart_irq_tx_eval #(.CNT_W(CNT_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .fifo_en  (fifo_en),
        .thr_full (thr_full),
        .count    (tx_count),
        .trig     (tx_trig),
        .hit      (tx_hit)
    );

    uart_irq_rx_eval #(.CNT_W(CNT_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .fifo_en  (fifo_en),
        .rhr_full (rhr_full),
        .count    (rx_count),
        .trig     (rx_trig),
        .hit      (rx_hit)
    );

    uart_irq_pin_reg u_pin (
        .clk        (clk),
        .rst_n      (rst_n),
        .intel_mode (intel_mode),
        .tx_ien     (tx_ien),
        .rx_ien     (rx_ien),
        .tx_hit     (tx_hit),
        .rx_hit     (rx_hit),
        .pin        (irq_pin)
    );

    AST_PIN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq_pin == ($past(intel_mode) ==
            (($past(tx_ien) && $past(tx_hit)) || ($past(rx_ien) && $past(rx_hit)))))); // R9
    AST_MODE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $changed(intel_mode) && $stable(tx_ien) && $stable(rx_ien)
         && $stable(tx_hit) && $stable(rx_hit)) |=> (irq_pin != $past(irq_pin))); // R11

endmodule

// File: tb/uart_irq_gen_test.sv
module uart_irq_gen_test;
    localparam int CNT_W = 5;

    typedef struct {
        bit    exp;
        string tag;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fifo_en = 1'b0, dma_mode = 1'b0, intel_mode = 1'b1;
    logic tx_ien = 1'b0, rx_ien = 1'b0, thr_full = 1'b0, rhr_full = 1'b0;
    logic [CNT_W-1:0] tx_count = '0, tx_trig = '0, rx_count = '0, rx_trig = '0;
    logic irq_pin;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    bit have_prev = 1'b0;
    bit prev_exp = 1'b0;
    item_t sb[$];

    always #4 clk = ~clk;

    uart_irq_gen #(.FIFO_DEPTH(16), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .dma_mode(dma_mode),
        .intel_mode(intel_mode), .tx_ien(tx_ien), .rx_ien(rx_ien),
        .thr_full(thr_full), .rhr_full(rhr_full), .tx_count(tx_count),
        .tx_trig(tx_trig), .rx_count(rx_count), .rx_trig(rx_trig), .irq_pin(irq_pin)
    );

    function automatic bit model();
        bit tx_req, rx_req, act;
        if (!rst_n) return !intel_mode;
        tx_req = fifo_en ? ((tx_count < tx_trig) || (tx_count == 0)) : !thr_full;
        rx_req = fifo_en ? ((rx_count != 0) && (rx_count >= rx_trig)) : rhr_full;
        act = (tx_ien && tx_req) || (rx_ien && rx_req);
        return intel_mode ? act : !act;
    endfunction

    // Inputs already updated at a negedge; check the pin has not moved yet (R9), queue the new expectation
    task automatic commit(input string tag);
        item_t it;
        #1;
        if (have_prev) begin
            total++;
            if (irq_pin !== prev_exp) begin
                bad++;
                $display("FAIL R9 early change (%s): got %b expected %b", tag, irq_pin, prev_exp);
            end
        end
        it.exp = model();
        it.tag = tag;
        sb.push_back(it);
        prev_exp = it.exp;
        have_prev = 1'b1;
    endtask

    task automatic fifo_cfg(input bit fe, input int tc, input int tt, input int rc, input int rt,
                            input bit ti, input bit ri, input string tag);
        @(negedge clk);
        fifo_en = fe; tx_count = tc[CNT_W-1:0]; tx_trig = tt[CNT_W-1:0];
        rx_count = rc[CNT_W-1:0]; rx_trig = rt[CNT_W-1:0]; tx_ien = ti; rx_ien = ri;
        commit(tag);
    endtask

    task automatic reg_cfg(input bit thr, input bit rhr, input bit ti, input bit ri, input string tag);
        @(negedge clk);
        fifo_en = 1'b0; thr_full = thr; rhr_full = rhr; tx_ien = ti; rx_ien = ri;
        commit(tag);
    endtask

    task automatic set_mode(input bit im, input bit dm, input string tag);
        @(negedge clk);
        intel_mode = im; dma_mode = dm;
        commit(tag);
    endtask

    task automatic set_rst(input bit r, input bit im, input string tag);
        @(negedge clk);
        rst_n = r; intel_mode = im;
        commit(tag);
    endtask

    // Monitor: two ns after each rising edge, compare against queued expectation
    always begin
        item_t it;
        @(posedge clk);
        #2;
        if (sb.size() > 0) begin
            it = sb.pop_front();
            total++;
            if (irq_pin !== it.exp) begin
                bad++;
                $display("FAIL %s: got %b expected %b", it.tag, irq_pin, it.exp);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired: got hang expected finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        set_rst(1'b0, 1'b1, "R10 reset intel");
        set_rst(1'b0, 1'b0, "R10 reset motorola");
        set_rst(1'b0, 1'b1, "R10 reset intel again");
        set_rst(1'b1, 1'b1, "R10 release");

        reg_cfg(1'b0, 1'b0, 1'b1, 1'b0, "R1 thr empty");
        reg_cfg(1'b1, 1'b0, 1'b1, 1'b0, "R1 thr full");
        reg_cfg(1'b1, 1'b1, 1'b0, 1'b1, "R3 rhr held");
        reg_cfg(1'b1, 1'b0, 1'b0, 1'b1, "R3 rhr empty");
        reg_cfg(1'b1, 1'b1, 1'b1, 1'b0, "R8 rx masked");
        reg_cfg(1'b0, 1'b0, 1'b0, 1'b1, "R8 tx masked");
        reg_cfg(1'b0, 1'b1, 1'b1, 1'b1, "R8 both on");

        fifo_cfg(1'b1, 0, 4, 0, 4, 1'b1, 1'b0, "R2 tx empty");
        fifo_cfg(1'b1, 3, 4, 0, 4, 1'b1, 1'b0, "R2 tx below");
        fifo_cfg(1'b1, 4, 4, 0, 4, 1'b1, 1'b0, "R7 tx equal");
        fifo_cfg(1'b1, 8, 4, 0, 4, 1'b1, 1'b0, "R2 tx above");
        fifo_cfg(1'b1, 0, 0, 0, 4, 1'b1, 1'b0, "R2 tx empty trig0");
        fifo_cfg(1'b1, 1, 0, 0, 4, 1'b1, 1'b0, "R2 tx one trig0");
        fifo_cfg(1'b1, 8, 4, 3, 4, 1'b0, 1'b1, "R4 rx below");
        fifo_cfg(1'b1, 8, 4, 4, 4, 1'b0, 1'b1, "R7 rx equal");
        fifo_cfg(1'b1, 8, 4, 9, 4, 1'b0, 1'b1, "R4 rx above");
        fifo_cfg(1'b1, 8, 4, 0, 0, 1'b0, 1'b1, "R4 rx empty trig0");
        fifo_cfg(1'b1, 8, 4, 16, 16, 1'b0, 1'b1, "R7 rx full depth");
        fifo_cfg(1'b1, 2, 4, 9, 4, 1'b0, 1'b0, "R8 both masked");
        fifo_cfg(1'b1, 2, 4, 1, 4, 1'b1, 1'b1, "R8 tx only");

        set_mode(1'b0, 1'b0, "R11 flip to motorola");
        set_mode(1'b1, 1'b0, "R11 flip to intel");
        set_mode(1'b0, 1'b0, "R5 active low");
        fifo_cfg(1'b1, 8, 4, 1, 4, 1'b1, 1'b1, "R5 active low idle");
        set_mode(1'b0, 1'b1, "R6 dma set idle");
        fifo_cfg(1'b1, 2, 4, 1, 4, 1'b1, 1'b1, "R6 dma set active");
        set_mode(1'b1, 1'b1, "R6 dma set intel");
        reg_cfg(1'b1, 1'b1, 1'b0, 1'b1, "R6 dma set reg mode");
        set_mode(1'b1, 1'b0, "R6 dma cleared");

        set_rst(1'b0, 1'b0, "R10 reset mid-run motorola");
        set_rst(1'b1, 1'b0, "R10 release motorola");

        @(posedge clk);
        @(posedge clk);
        #3;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule